// File: doc/BRIEF.md
# Signed and Logical Subtract Unit

This block is a 32-bit subtractor that serves a fixed-point execution pipeline. An operation is presented on a single-cycle request strobe. The request carries two operands, an operation select and the current fixed-point-overflow mask. One clock later the unit presents three results: the difference, a 2-bit condition code and an overflow interrupt request, with a one-cycle valid strobe. The results stay on the outputs until the next request.

There are four operation selects:

- **Register-register signed** (code 00) and **register-storage signed** (code 01) both treat the operands as 32-bit two's-complement values.
- **Halfword signed** (code 10) takes the second operand from its low 16 bits, sign-extended to 32 bits.
- **Logical** (code 11) computes the first operand plus the one's complement of the second plus one, as unsigned arithmetic. The condition code then reports the carry out and whether the result is zero.

Sequencing is a two-state machine:

- `S_IDLE`: no result is being presented.
- `S_DONE`: the registered results are being presented with the valid strobe high.
- `GO_DONE`: the transition taken from either state when a request is sampled.
- `GO_IDLE`: the transition taken from either state when no request is sampled.

Top module: `sub_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any request, `vld_o`, `diff_o`, `cc_o` and `ovf_irq_o` are all zero.
- R2: A request sampled at a rising edge sets `vld_o` high for the cycle after that edge, so results appear after one register stage. Without a request `vld_o` is low and `diff_o`, `cc_o` and `ovf_irq_o` keep their values.
- R3: For op codes 00 and 01, `diff_o` is `opa_i - opb_i` modulo 2^32. `cc_o` is 0 for a zero difference, 1 for a negative one and 2 for a positive one. It is 3 when signed overflow occurs, and in that case `diff_o` still holds the truncated 32-bit result.
- R4: For op code 10, the low 16 bits of `opb_i` are sign-extended before subtracting, and bits 31..16 of `opb_i` have no effect on any output. The condition code follows R3.
- R5: `ovf_irq_o` is 1 exactly when a signed op (00, 01, 10) overflows and `ovf_mask_i` was 1 with the request. Overflow with the mask at 0 still gives `cc_o` = 3.
- R6: Subtracting 0x80000000 from 0x80000000 in a signed mode gives zero, `cc_o` = 0 and no interrupt request.
- R7: For op code 11, `diff_o` is the low 32 bits of `opa_i + ~opb_i + 1`. `cc_o` is 1 for a nonzero result without carry out, 2 for a zero result with carry and 3 for a nonzero result with carry. Value 0 never occurs.
- R8: For op code 11, a zero result always comes with a carry, and subtracting zero always carries. `ovf_irq_o` is 0 whatever the mask.
- R9: The state machine moves to `S_DONE` on every sampled request and to `S_IDLE` otherwise, and `vld_o` is high exactly in `S_DONE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request strobe |
| op_i | input | 2 | Operation select: 00 reg-reg signed, 01 reg-storage signed, 10 halfword signed, 11 logical |
| opa_i | input | 32 | First operand (minuend) |
| opb_i | input | 32 | Second operand (subtrahend); only bits 15..0 used for op 10 |
| ovf_mask_i | input | 1 | Fixed-point-overflow mask, sampled with the request |
| vld_o | output | 1 | Result valid, one cycle per request |
| diff_o | output | 32 | Registered difference |
| cc_o | output | 2 | Registered condition code |
| ovf_irq_o | output | 1 | Registered overflow interrupt request |

## Verification
Signed-overflow detection and the mask-gated interrupt request resolve in the same cycle from the same operands. The bench provokes this with pairs such as 0x80000000 minus 1 and 0x7FFFFFFF minus -1, issued once with the mask set and once with it clear. It judges that `cc_o` is 3 in both cases, that the truncated difference is present and that only the masked-on request raises `ovf_irq_o`. A second coincidence is a new request arriving in the cycle a previous result is being presented. Back-to-back requests check that each result replaces the last without a gap in `vld_o`.

// File: rtl/subu_pkg.sv
package subu_pkg;

    typedef enum logic [1:0] {
        OP_REG   = 2'b00,
        OP_STOR  = 2'b01,
        OP_HALF  = 2'b10,
        OP_LOGIC = 2'b11
    } subu_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } subu_state_e;

    localparam logic [1:0] CC_SGN_ZERO = 2'd0;
    localparam logic [1:0] CC_SGN_NEG  = 2'd1;
    localparam logic [1:0] CC_SGN_POS  = 2'd2;
    localparam logic [1:0] CC_SGN_OVF  = 2'd3;
    localparam logic [1:0] CC_LOG_NZNC = 2'd1;
    localparam logic [1:0] CC_LOG_ZC   = 2'd2;
    localparam logic [1:0] CC_LOG_NZC  = 2'd3;

endpackage

// File: rtl/subu_operand_prep.sv
module subu_operand_prep
    import subu_pkg::*;
#(
    parameter int W  = 32,
    parameter int HW = 16
) (
    input  subu_op_e       op,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   opb_ext
);
    localparam int EXT = W - HW;

    logic [W-1:0] half_ext;

    generate
        if (EXT > 0) begin : g_ext
            assign half_ext = {{EXT{opb[HW-1]}}, opb[HW-1:0]};
        end else begin : g_noext
            assign half_ext = opb;
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_HALF: opb_ext = half_ext;
            default: opb_ext = opb;
        endcase
    end
endmodule

// File: rtl/subu_core.sv
module subu_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] diff,
    output logic         carry,
    output logic         sovf
);
    logic [W:0] sum;

    always_comb begin
        // minuend plus inverted subtrahend plus one low-order one
        sum   = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        diff  = sum[W-1:0];
        carry = sum[W];
        sovf  = (a[W-1] ^ b[W-1]) & (sum[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/subu_cc_encode.sv
module subu_cc_encode
    import subu_pkg::*;
#(
    parameter int W = 32
) (
    input  subu_op_e     op,
    input  logic [W-1:0] diff,
    input  logic         carry,
    input  logic         sovf,
    input  logic         mask,
    output logic [1:0]   cc,
    output logic         irq
);
    logic is_zero;

    always_comb begin
        is_zero = (diff == '0);
        cc      = CC_SGN_ZERO;
        irq     = 1'b0;
        unique case (op)
            OP_LOGIC: begin
                if (!carry)       cc = CC_LOG_NZNC;
                else if (is_zero) cc = CC_LOG_ZC;
                else              cc = CC_LOG_NZC;
            end
            default: begin
                if (sovf)              cc = CC_SGN_OVF;
                else if (is_zero)      cc = CC_SGN_ZERO;
                else if (diff[W-1])    cc = CC_SGN_NEG;
                else                   cc = CC_SGN_POS;
                irq = sovf & mask;
            end
        endcase
    end
endmodule

// File: rtl/sub_unit.sv
module sub_unit
    import subu_pkg::*;
#(
    parameter int W  = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [1:0]    op_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic          ovf_mask_i,
    output logic          vld_o,
    output logic [W-1:0]  diff_o,
    output logic [1:0]    cc_o,
    output logic          ovf_irq_o
);
    subu_state_e state_q, state_d;
    subu_op_e    op_e;

    logic [W-1:0] opb_ext;
    logic [W-1:0] diff_c;
    logic         carry_c;
    logic         sovf_c;
    logic [1:0]   cc_c;
    logic         irq_c;

    logic [W-1:0] diff_q;
    logic [1:0]   cc_q;
    logic         irq_q;

    assign op_e = subu_op_e'(op_i);

    subu_operand_prep #(.W(W), .HW(HW)) prep_i (
        .op      (op_e),
        .opb     (opb_i),
        .opb_ext (opb_ext)
    );

    subu_core #(.W(W)) core_i (
        .a     (opa_i),
        .b     (opb_ext),
        .diff  (diff_c),
        .carry (carry_c),
        .sovf  (sovf_c)
    );

    subu_cc_encode #(.W(W)) cc_i (
        .op    (op_e),
        .diff  (diff_c),
        .carry (carry_c),
        .sovf  (sovf_c),
        .mask  (ovf_mask_i),
        .cc    (cc_c),
        .irq   (irq_c)
    );

    // next-state: GO_DONE on request, GO_IDLE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = req_i ? S_DONE : S_IDLE;
            S_DONE: state_d = req_i ? S_DONE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q <= '0;
            cc_q   <= '0;
            irq_q  <= 1'b0;
        end else if (req_i) begin
            diff_q <= diff_c;
            cc_q   <= cc_c;
            irq_q  <= irq_c;
        end
    end

    // outputs
    always_comb begin
        vld_o     = (state_q == S_DONE);
        diff_o    = diff_q;
        cc_o      = cc_q;
        ovf_irq_o = irq_q;
    end
endmodule

// File: rtl/sub_unit_chk.sv
module sub_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_i,
    input logic [1:0]   op_i,
    input logic         ovf_mask_i,
    input logic         vld_o,
    input logic [W-1:0] diff_o,
    input logic [1:0]   cc_o,
    input logic         ovf_irq_o
);
    AST_REQ_GIVES_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> vld_o); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!vld_o && $stable(diff_o) && $stable(cc_o) && $stable(ovf_irq_o))); // R9
    AST_IRQ_ONLY_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq_o |-> (cc_o == 2'd3)); // R5
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ovf_mask_i) |=> !ovf_irq_o); // R5
    AST_LOGIC_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'b11) |=> !ovf_irq_o); // R8
    AST_LOGIC_CC_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'b11) |=> (cc_o != 2'd0)); // R7
    AST_LOGIC_ZERO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'b11) |=> ((diff_o == '0) == (cc_o == 2'd2))); // R8
endmodule

bind sub_unit sub_unit_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .op_i       (op_i),
    .ovf_mask_i (ovf_mask_i),
    .vld_o      (vld_o),
    .diff_o     (diff_o),
    .cc_o       (cc_o),
    .ovf_irq_o  (ovf_irq_o)
);

// File: tb/sub_unit_tb_top.sv
module sub_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic        ovf_mask_i = 1'b0;
    logic        vld_o;
    logic [31:0] diff_o;
    logic [1:0]  cc_o;
    logic        ovf_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sub_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .ovf_mask_i(ovf_mask_i),
        .vld_o(vld_o), .diff_o(diff_o), .cc_o(cc_o), .ovf_irq_o(ovf_irq_o)
    );

    logic [31:0] corners [5];
    initial begin
        corners[0] = 32'h0000_0000;
        corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF;
        corners[3] = 32'h7FFF_FFFF;
        corners[4] = 32'h8000_0000;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // independent expectation from the requirements
    task automatic model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic m, output logic [31:0] d, output logic [1:0] c,
                         output logic irq);
        longint sa, sb, sd;
        logic [32:0] u;
        if (op == 2'b11) begin
            u = {1'b0, a} + {1'b0, ~b} + 33'd1;
            d = u[31:0];
            c = !u[32] ? 2'd1 : (d == 0 ? 2'd2 : 2'd3);
            irq = 1'b0;
        end else begin
            sa = longint'($signed(a));
            sb = (op == 2'b10) ? longint'($signed(b[15:0])) : longint'($signed(b));
            sd = sa - sb;
            d = sd[31:0];
            if (sd > 64'sd2147483647 || sd < -64'sd2147483648) begin
                c = 2'd3; irq = m;
            end else begin
                c = (sd == 0) ? 2'd0 : (sd < 0 ? 2'd1 : 2'd2);
                irq = 1'b0;
            end
        end
    endtask

    // drive one request, check the registered result the next cycle
    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic m, input string rq);
        logic [31:0] ed; logic [1:0] ec; logic ei;
        model(op, a, b, m, ed, ec, ei);
        @(negedge clk);
        req_i = 1'b1; op_i = op; opa_i = a; opb_i = b; ovf_mask_i = m;
        @(negedge clk);
        req_i = 1'b0;
        chk(vld_o == 1'b1, "R2", "vld", {31'd0, vld_o}, 32'd1);
        chk(diff_o == ed, rq, "diff", diff_o, ed);
        chk(cc_o == ec, rq, "cc", {30'd0, cc_o}, {30'd0, ec});
        chk(ovf_irq_o == ei, rq, "irq", {31'd0, ovf_irq_o}, {31'd0, ei});
    endtask

    task automatic t_reset();
        chk(vld_o == 0 && diff_o == 0 && cc_o == 0 && ovf_irq_o == 0, "R1", "in reset",
            {vld_o, ovf_irq_o, cc_o, diff_o[27:0]}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(vld_o == 0 && diff_o == 0 && cc_o == 0 && ovf_irq_o == 0, "R1", "after reset",
            {vld_o, ovf_irq_o, cc_o, diff_o[27:0]}, 32'd0);
    endtask

    task automatic t_signed_corners();
        for (int op = 0; op < 2; op++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    apply(op[1:0], corners[i], corners[j], 1'b1, "R3");
    endtask

    task automatic t_halfword();
        apply(2'b10, 32'd5, 32'hABCD_FFFF, 1'b1, "R4");   // -1 low half
        apply(2'b10, 32'd5, 32'h1234_8000, 1'b1, "R4");   // -32768
        apply(2'b10, 32'h8000_0000, 32'hFFFF_0001, 1'b1, "R4");
        apply(2'b10, 32'h7FFF_FFFF, 32'h0000_FFFF, 1'b1, "R4");
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                apply(2'b10, corners[i], corners[j] ^ 32'h5A5A_0000, 1'b0, "R4");
    endtask

    task automatic t_overflow_mask();
        apply(2'b00, 32'h8000_0000, 32'd1, 1'b1, "R5");
        apply(2'b00, 32'h8000_0000, 32'd1, 1'b0, "R5");
        apply(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
        apply(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R5");
        apply(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R3");
        chk(diff_o == 32'hFFFF_FFFF, "R3", "truncated diff", diff_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_minneg();
        apply(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b1, "R6");
        chk(cc_o == 2'd0 && !ovf_irq_o, "R6", "zero no ovf", {30'd0, cc_o}, 32'd0);
    endtask

    task automatic t_logical();
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                apply(2'b11, corners[i], corners[j], 1'b1, "R7");
        apply(2'b11, 32'd3, 32'd0, 1'b1, "R8");
        chk(cc_o == 2'd3, "R8", "minus zero carries", {30'd0, cc_o}, 32'd3);
        apply(2'b11, 32'd0, 32'd0, 1'b1, "R8");
        chk(cc_o == 2'd2, "R8", "zero with carry", {30'd0, cc_o}, 32'd2);
        apply(2'b11, 32'd1, 32'd2, 1'b1, "R7");
        chk(cc_o == 2'd1, "R7", "borrow", {30'd0, cc_o}, 32'd1);
    endtask

    task automatic t_hold();
        logic [31:0] d0; logic [1:0] c0;
        apply(2'b00, 32'd100, 32'd7, 1'b1, "R2");
        d0 = diff_o; c0 = cc_o;
        op_i = 2'b11; opa_i = 32'hDEAD_BEEF; opb_i = 32'h1; ovf_mask_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(vld_o == 0, "R9", "idle vld", {31'd0, vld_o}, 32'd0);
        chk(diff_o == d0 && cc_o == c0, "R2", "hold", diff_o, d0);
        // back-to-back requests: vld stays high, each result replaces the last
        @(negedge clk);
        req_i = 1'b1; op_i = 2'b00; opa_i = 32'd10; opb_i = 32'd3;
        @(negedge clk);
        chk(vld_o && diff_o == 32'd7, "R9", "b2b first", diff_o, 32'd7);
        op_i = 2'b11; opa_i = 32'd3; opb_i = 32'd10;
        @(negedge clk);
        req_i = 1'b0;
        chk(vld_o && diff_o == 32'hFFFF_FFF9 && cc_o == 2'd1, "R9", "b2b second",
            diff_o, 32'hFFFF_FFF9);
        @(negedge clk);
        chk(!vld_o, "R9", "back to idle", {31'd0, vld_o}, 32'd0);
    endtask

    task automatic t_random();
        for (int k = 0; k < 400; k++)
            apply(2'($urandom), $urandom, $urandom, 1'($urandom), "R3");
    endtask

    initial begin
        t_reset();
        t_signed_corners();
        t_halfword();
        t_overflow_mask();
        t_minneg();
        t_logical();
        t_hold();
        t_random();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule